// File: doc/BRIEF.md
# Host Parallel Mailbox Port

This block connects an external host to an on-chip processor through an 8-bit parallel register window. The window has four addresses. Two bits of address select among a message mailbox, a control/status word, and two write-only byte streams. Each stream feeds its own small input FIFO, which the processor drains through a pop interface.

The message address holds two independent one-byte mailboxes. A host write fills the inbound byte and raises a busy flag, which the processor clears by taking the byte. A processor write fills the outbound byte and raises a ready flag, which the host clears by reading the message address. The control word reports both flags and an almost-full flag for each stream. Through the same word the host can hold either stream in reset, which flushes that stream's FIFO.

Top module: `hostMailboxPort`

## Requirements
- R1: Host reads return the outbound mailbox byte at address 2'b00, the control word at 2'b01, and 8'h00 at the data addresses 2'b10 and 2'b11.
- R2: A host write to address 2'b00 stores the byte on `cpuInData` and sets `inBusy` from the next cycle. The flag is also reported in control bit 2.
- R3: A processor read (`cpuInRd`) clears `inBusy`. If a host message write happens in the same cycle, the flag stays 1 and the new byte is kept.
- R4: A processor write (`cpuOutWr`) stores the outbound byte and sets `outReady`, which is also reported in control bit 1. A host read of 2'b00 clears the flag. If both happen in the same cycle, the host gets the old byte and the flag stays 1.
- R5: Host writes to 2'b10 (linear PCM stream) and 2'b11 (compressed stream) push bytes into that stream's FIFO. The processor pops them in arrival order. `*Valid` is high while the FIFO is not empty.
- R6: A stream's almost-full flag is 1 while its FIFO holds 12 or more bytes. It appears in control bit 4 for the PCM stream and bit 3 for the compressed stream.
- R7: Each FIFO holds 16 bytes. A host write to a full FIFO is dropped.
- R8: Control bits 6 (compressed stream) and 5 (PCM stream) are host-writable hold bits and read back as written. While a hold bit is 1, that FIFO is flushed, host writes to it are dropped, and its almost-full bit reads 0.
- R9: Control bits 7 and 0 always read 0. After global reset, `inBusy`, `outReady` and both hold bits are 0 and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous global reset |
| hostAddr | input | 2 | Host register address |
| hostWr | input | 1 | Host write strobe, one byte per cycle |
| hostRd | input | 1 | Host read strobe; side effects take place at the clock edge |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational from the address) |
| cpuInRd | input | 1 | Processor takes the inbound mailbox byte |
| cpuInData | output | 8 | Inbound mailbox byte |
| inBusy | output | 1 | Inbound byte not yet taken |
| cpuOutWr | input | 1 | Processor writes the outbound mailbox byte |
| cpuOutData | input | 8 | Outbound byte from the processor |
| outReady | output | 1 | Outbound byte not yet read by the host |
| pcmPop | input | 1 | Pop the PCM stream FIFO |
| pcmData | output | 8 | Head of the PCM stream FIFO |
| pcmValid | output | 1 | PCM stream FIFO not empty |
| cmpPop | input | 1 | Pop the compressed stream FIFO |
| cmpData | output | 8 | Head of the compressed stream FIFO |
| cmpValid | output | 1 | Compressed stream FIFO not empty |

## Verification
The handshake flags are each set by one side and cleared by the other, so a set and a clear can fall in the same cycle. The bench provokes this twice. It asserts a host message write together with `cpuInRd`, and a host message read together with `cpuOutWr`. In both cases it judges that the flag stays 1, that the host sees the old outbound byte, and that the inbound byte is the new one. A scoreboard queue per stream also checks the byte order through FIFO filling, overflow, drain and flush.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  localparam int BYTE_W = 8;
  localparam int N_CHAN = 2;
  localparam int CH_PCM = 0;
  localparam int CH_CMP = 1;

  typedef enum logic [1:0] {
    ADDR_MSG = 2'b00,
    ADDR_CTL = 2'b01,
    ADDR_PCM = 2'b10,
    ADDR_CMP = 2'b11
  } hmpAddr_e;

  // control word bit positions
  localparam int CTL_CMP_HOLD = 6;
  localparam int CTL_PCM_HOLD = 5;
  localparam int CTL_PCM_AF   = 4;
  localparam int CTL_CMP_AF   = 3;
  localparam int CTL_BUSY     = 2;
  localparam int CTL_READY    = 1;

  typedef struct packed {
    logic              msgLoad;
    logic [N_CHAN-1:0] push;
    logic [N_CHAN-1:0] flush;
  } hmpStrobe_t;
endpackage

// File: rtl/hmp_fifo.sv
module hmp_fifo #(
  parameter int WIDTH    = 8,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             notEmpty,
  output logic             almostFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign doPush = push && (count != CNT_W'(DEPTH)) && !flush;
  assign doPop  = pop && (count != '0) && !flush;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  assign dout       = mem[rdPtr];
  assign notEmpty   = (count != '0);
  assign almostFull = (count >= CNT_W'(AF_LEVEL));
endmodule

// File: rtl/hmp_datapath.sv
module hmp_datapath
  import hmp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int AF_LEVEL   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  hmpStrobe_t        stb,
  input  logic [BYTE_W-1:0] hostWdata,
  input  logic              cpuOutWr,
  input  logic [BYTE_W-1:0] cpuOutData,
  output logic [BYTE_W-1:0] inByte,
  output logic [BYTE_W-1:0] outByte,
  input  logic [N_CHAN-1:0] popVec,
  output logic [BYTE_W-1:0] headByte [N_CHAN],
  output logic [N_CHAN-1:0] validVec,
  output logic [N_CHAN-1:0] afVec
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inByte  <= '0;
      outByte <= '0;
    end else begin
      if (stb.msgLoad) inByte  <= hostWdata;
      if (cpuOutWr)    outByte <= cpuOutData;
    end
  end

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    hmp_fifo #(
      .WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH), .AF_LEVEL(AF_LEVEL)
    ) u_fifo (
      .clk       (clk),
      .rstN      (rstN),
      .flush     (stb.flush[ch]),
      .push      (stb.push[ch]),
      .din       (hostWdata),
      .pop       (popVec[ch]),
      .dout      (headByte[ch]),
      .notEmpty  (validVec[ch]),
      .almostFull(afVec[ch])
    );
  end
endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        holdReq,   // {compressed, pcm} from the written control byte
  input  logic              cpuInRd,
  input  logic              cpuOutWr,
  input  logic [BYTE_W-1:0] outByte,
  input  logic [N_CHAN-1:0] afVec,
  output hmpStrobe_t        stb,
  output logic              inBusy,
  output logic              outReady,
  output logic [N_CHAN-1:0] holdVec,
  output logic [BYTE_W-1:0] hostRdata
);
  hmpAddr_e addr;
  logic msgWr, msgRd, ctlWr;
  logic [N_CHAN-1:0] afShown;

  assign addr  = hmpAddr_e'(hostAddr);
  assign msgWr = hostWr && (addr == ADDR_MSG);
  assign msgRd = hostRd && (addr == ADDR_MSG);
  assign ctlWr = hostWr && (addr == ADDR_CTL);

  always_comb begin
    stb             = '0;
    stb.msgLoad     = msgWr;
    stb.push[CH_PCM] = hostWr && (addr == ADDR_PCM) && !holdVec[CH_PCM];
    stb.push[CH_CMP] = hostWr && (addr == ADDR_CMP) && !holdVec[CH_CMP];
    stb.flush       = holdVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBusy   <= 1'b0;
      outReady <= 1'b0;
      holdVec  <= '0;
    end else begin
      if (msgWr)        inBusy <= 1'b1;
      else if (cpuInRd) inBusy <= 1'b0;
      if (cpuOutWr)     outReady <= 1'b1;
      else if (msgRd)   outReady <= 1'b0;
      if (ctlWr) begin
        holdVec[CH_CMP] <= holdReq[1];
        holdVec[CH_PCM] <= holdReq[0];
      end
    end
  end

  assign afShown = afVec & ~holdVec;

  always_comb begin
    hostRdata = '0;
    unique case (addr)
      ADDR_MSG: hostRdata = outByte;
      ADDR_CTL: begin
        hostRdata[CTL_CMP_HOLD] = holdVec[CH_CMP];
        hostRdata[CTL_PCM_HOLD] = holdVec[CH_PCM];
        hostRdata[CTL_PCM_AF]   = afShown[CH_PCM];
        hostRdata[CTL_CMP_AF]   = afShown[CH_CMP];
        hostRdata[CTL_BUSY]     = inBusy;
        hostRdata[CTL_READY]    = outReady;
      end
      default: hostRdata = '0;
    endcase
  end
endmodule

// File: rtl/hostMailboxPort.sv
module hostMailboxPort
  import hmp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int AF_LEVEL   = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  hostAddr,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  input  logic        cpuInRd,
  output logic [7:0]  cpuInData,
  output logic        inBusy,
  input  logic        cpuOutWr,
  input  logic [7:0]  cpuOutData,
  output logic        outReady,
  input  logic        pcmPop,
  output logic [7:0]  pcmData,
  output logic        pcmValid,
  input  logic        cmpPop,
  output logic [7:0]  cmpData,
  output logic        cmpValid
);
  hmpStrobe_t        stb;
  logic [BYTE_W-1:0] outByte;
  logic [BYTE_W-1:0] headByte [N_CHAN];
  logic [N_CHAN-1:0] validVec, afVec, holdVec, popVec;

  assign popVec[CH_PCM] = pcmPop;
  assign popVec[CH_CMP] = cmpPop;

  hmp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .holdReq  ({hostWdata[CTL_CMP_HOLD], hostWdata[CTL_PCM_HOLD]}),
    .cpuInRd  (cpuInRd),
    .cpuOutWr (cpuOutWr),
    .outByte  (outByte),
    .afVec    (afVec),
    .stb      (stb),
    .inBusy   (inBusy),
    .outReady (outReady),
    .holdVec  (holdVec),
    .hostRdata(hostRdata)
  );

  hmp_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .AF_LEVEL(AF_LEVEL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWdata (hostWdata),
    .cpuOutWr  (cpuOutWr),
    .cpuOutData(cpuOutData),
    .inByte    (cpuInData),
    .outByte   (outByte),
    .popVec    (popVec),
    .headByte  (headByte),
    .validVec  (validVec),
    .afVec     (afVec)
  );

  assign pcmData  = headByte[CH_PCM];
  assign cmpData  = headByte[CH_CMP];
  assign pcmValid = validVec[CH_PCM];
  assign cmpValid = validVec[CH_CMP];
endmodule

// File: rtl/hmp_checker.sv
module hmp_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] hostAddr,
  input logic       hostWr,
  input logic       hostRd,
  input logic [7:0] hostRdata,
  input logic       cpuInRd,
  input logic       inBusy,
  input logic       cpuOutWr,
  input logic       outReady,
  input logic       pcmValid,
  input logic       cmpValid,
  input logic [1:0] holdVec
);
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'b00) |=> inBusy); // R2
  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cpuInRd && !(hostWr && hostAddr == 2'b00)) |=> !inBusy); // R3
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rstN)
    cpuOutWr |=> outReady); // R4
  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'b00 && !cpuOutWr) |=> !outReady); // R4
  AST_DATA_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hostAddr[1] |-> (hostRdata == 8'h00)); // R1
  AST_HOLD_FLUSHED: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdVec[0]) |-> !pcmValid); // R8
  AST_HOLD_FLUSHED_CMP: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdVec[1]) |-> !cmpValid); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'b01) |-> (hostRdata[7] == 1'b0 && hostRdata[0] == 1'b0)); // R9
  AST_AF_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'b01 && hostRdata[4]) |-> pcmValid); // R6
endmodule

bind hostMailboxPort hmp_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostAddr (hostAddr),
  .hostWr   (hostWr),
  .hostRd   (hostRd),
  .hostRdata(hostRdata),
  .cpuInRd  (cpuInRd),
  .inBusy   (inBusy),
  .cpuOutWr (cpuOutWr),
  .outReady (outReady),
  .pcmValid (pcmValid),
  .cmpValid (cmpValid),
  .holdVec  (holdVec)
);

// File: tb/hostMailboxPort_tb.sv
module hostMailboxPort_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] hostAddr;
  logic       hostWr, hostRd;
  logic [7:0] hostWdata, hostRdata;
  logic       cpuInRd, inBusy, cpuOutWr, outReady;
  logic [7:0] cpuInData, cpuOutData;
  logic       pcmPop, pcmValid, cmpPop, cmpValid;
  logic [7:0] pcmData, cmpData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model
  bit busyM, readyM, pcmHoldM, cmpHoldM;
  logic [7:0] pcmQ[$];
  logic [7:0] cmpQ[$];
  logic [7:0] rd;

  always #4 clk = ~clk;

  hostMailboxPort u_dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctlExp();
    logic [7:0] v = 8'h00;
    v[6] = cmpHoldM;
    v[5] = pcmHoldM;
    v[4] = !pcmHoldM && pcmQ.size() >= 12;
    v[3] = !cmpHoldM && cmpQ.size() >= 12;
    v[2] = busyM;
    v[1] = readyM;
    return v;
  endfunction

  task automatic hostWrite(logic [1:0] a, logic [7:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(posedge clk); #1 hostWr = 1'b0;
    case (a)
      2'b00: busyM = 1'b1;
      2'b01: begin
        cmpHoldM = d[6]; pcmHoldM = d[5];
        if (cmpHoldM) cmpQ.delete();
        if (pcmHoldM) pcmQ.delete();
      end
      2'b10: if (!pcmHoldM && pcmQ.size() < 16) pcmQ.push_back(d);
      default: if (!cmpHoldM && cmpQ.size() < 16) cmpQ.push_back(d);
    endcase
  endtask

  task automatic hostRead(logic [1:0] a, output logic [7:0] d);
    hostAddr = a; hostRd = 1'b1;
    @(negedge clk); d = hostRdata;
    @(posedge clk); #1 hostRd = 1'b0;
    if (a == 2'b00) readyM = 1'b0;
  endtask

  task automatic popChan(bit cmp, int n);
    if (cmp) cmpPop = 1'b1; else pcmPop = 1'b1;
    repeat (n) @(posedge clk);
    #1 cmpPop = 1'b0; pcmPop = 1'b0;
  endtask

  // scoreboard monitor: compares popped heads against the expected queues
  always @(negedge clk) begin
    if (rstN && pcmPop) begin
      if (pcmQ.size() != 0) begin
        check("R5 pcm valid", {7'b0, pcmValid}, 8'h01);
        check("R5 pcm order", pcmData, pcmQ.pop_front());
      end else check("R7 pcm empty", {7'b0, pcmValid}, 8'h00);
    end
    if (rstN && cmpPop) begin
      if (cmpQ.size() != 0) begin
        check("R5 cmp valid", {7'b0, cmpValid}, 8'h01);
        check("R5 cmp order", cmpData, cmpQ.pop_front());
      end else check("R8 cmp empty", {7'b0, cmpValid}, 8'h00);
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hostAddr = 2'b00; hostWr = 1'b0; hostRd = 1'b0; hostWdata = 8'h00;
    cpuInRd = 1'b0; cpuOutWr = 1'b0; cpuOutData = 8'h00; pcmPop = 1'b0; cmpPop = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9 reset state
    hostRead(2'b01, rd); check("R9 ctl after reset", rd, 8'h00);
    check("R9 flags after reset", {6'b0, inBusy, outReady}, 8'h00);
    check("R9 fifos empty", {6'b0, pcmValid, cmpValid}, 8'h00);

    // R2 inbound mailbox
    hostWrite(2'b00, 8'hA5);
    check("R2 busy", {7'b0, inBusy}, 8'h01);
    check("R2 inbound byte", cpuInData, 8'hA5);
    hostRead(2'b01, rd); check("R2 ctl busy bit", rd, ctlExp());

    // R3 processor take clears busy
    cpuInRd = 1'b1; @(posedge clk); #1 cpuInRd = 1'b0; busyM = 1'b0;
    check("R3 busy cleared", {7'b0, inBusy}, 8'h00);

    // R3 same-cycle host write and processor take
    cpuInRd = 1'b1; hostWrite(2'b00, 8'h3C); cpuInRd = 1'b0;
    check("R3 concurrent busy stays", {7'b0, inBusy}, 8'h01);
    check("R3 concurrent new byte", cpuInData, 8'h3C);

    // R4 outbound mailbox
    cpuOutData = 8'h5A; cpuOutWr = 1'b1; @(posedge clk); #1 cpuOutWr = 1'b0; readyM = 1'b1;
    check("R4 ready", {7'b0, outReady}, 8'h01);
    hostRead(2'b01, rd); check("R4 ctl ready bit", rd, ctlExp());
    hostRead(2'b00, rd); check("R1 R4 outbound byte", rd, 8'h5A);
    check("R4 ready cleared", {7'b0, outReady}, 8'h00);

    // R4 same-cycle processor write and host read
    cpuOutData = 8'h5A; cpuOutWr = 1'b1; @(posedge clk); #1 cpuOutData = 8'h77;
    hostRead(2'b00, rd); cpuOutWr = 1'b0; readyM = 1'b1;
    check("R4 concurrent old byte", rd, 8'h5A);
    check("R4 concurrent ready stays", {7'b0, outReady}, 8'h01);
    hostRead(2'b00, rd); check("R4 new byte", rd, 8'h77);

    // R1 data addresses read zero
    hostRead(2'b10, rd); check("R1 pcm addr reads 0", rd, 8'h00);
    hostRead(2'b11, rd); check("R1 cmp addr reads 0", rd, 8'h00);

    // R6 / R7 PCM fill
    for (int i = 0; i < 11; i++) hostWrite(2'b10, 8'h10 + 8'(i));
    hostRead(2'b01, rd); check("R6 below level", rd[4:3], 2'b00);
    hostWrite(2'b10, 8'h1B);
    hostRead(2'b01, rd); check("R6 pcm almost full", rd, ctlExp());
    check("R6 pcm bit4", rd[4:3], 2'b10);
    for (int i = 0; i < 6; i++) hostWrite(2'b10, 8'h40 + 8'(i));
    check("R7 model holds 16", 8'(pcmQ.size()), 8'd16);
    popChan(1'b0, 17);
    check("R7 pcm drained", {7'b0, pcmValid}, 8'h00);

    // R6 / R8 compressed stream hold
    for (int i = 0; i < 12; i++) hostWrite(2'b11, 8'h80 + 8'(i));
    hostRead(2'b01, rd); check("R6 cmp bit3", rd[4:3], 2'b01);
    hostWrite(2'b01, 8'h40);
    hostRead(2'b01, rd); check("R8 cmp hold readback", rd, ctlExp());
    check("R8 cmp flushed", {7'b0, cmpValid}, 8'h00);
    hostWrite(2'b11, 8'hEE);
    @(posedge clk); #1;
    check("R8 write in hold dropped", {7'b0, cmpValid}, 8'h00);
    hostWrite(2'b01, 8'h00);
    hostWrite(2'b11, 8'hC1);
    hostWrite(2'b11, 8'hC2);
    popChan(1'b1, 3);

    // R9 / R8 reserved bits with all ones written
    hostWrite(2'b10, 8'h99);
    hostWrite(2'b01, 8'hFF);
    hostRead(2'b01, rd); check("R9 reserved bits zero", rd, ctlExp());
    check("R8 both holds", rd & 8'h60, 8'h60);
    @(posedge clk); #1;
    check("R8 pcm flushed", {7'b0, pcmValid}, 8'h00);
    hostWrite(2'b01, 8'h00);
    hostRead(2'b01, rd); check("R8 holds released", rd, ctlExp());

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule